// File: doc/BRIEF.md
# Interleaved Storage Request Arbiter

The block sits between four storage requesters and a doubleword-interleaved storage of eight elements. The four requesters are an instruction prefetch unit, an execution unit, a channel port and a console port. Each requester presents at most one request at a time: a fetch or a store, a byte address and, for a store, a doubleword of data. The prefetch unit settles its own internal contention before it presents a request, so the arbiter sees only one request from it. Address bits [5:3] choose the storage element. Each element has its own busy timer, so requests that target different elements proceed in parallel. Requests that collide on one element are resolved by a fixed rule: fetches go before stores, and within one kind a fixed requester order applies.

A grant is given combinationally, in the same cycle that the request is presented and the element is idle. The requester keeps its request asserted until it sees its grant, and changes it on the following cycle. Read data returns on the requester's own lane with a valid strobe a fixed five cycles after the grant. The lane position identifies the requester. The storage is modelled by a register array. A read occupies its element for 5 cycles and a write for 8 cycles, which is 285 ns and 456 ns at a 57 ns cycle.

Top module: `stor_arb`

## Requirements
- R1: The element is selected by byte address bits [5:3]. The word within an element is taken from bits [6 +: log2(WPB)], and bits [2:0] are ignored.
- R2: After reset, rd_vld is all zero and every element is idle, so a request presented in the first cycle after reset is granted in that cycle.
- R3: When an element is idle and both fetches (req_wr=0) and stores (req_wr=1) target it, a fetch is granted and no store is granted to that element in that cycle.
- R4: Among requests of the same kind to one element, the lowest requester index wins. Index 0 is the prefetch unit, 1 the execution unit, 2 the channel and 3 the console.
- R5: After a read grant in cycle c, that element grants nothing in cycles c+1..c+4 and can grant again in c+5. After a write grant, it grants nothing in c+1..c+7 and can grant again in c+8.
- R6: Requests to different elements are granted in the same cycle, with at most one grant per element and one gnt bit per requester.
- R7: A read granted to requester r in cycle c sets rd_vld[r] in cycle c+5 and in no other cycle because of that grant. rd_data lane r then carries the word stored at that address.
- R8: A store writes its data only when it is granted. A store that is not granted leaves the storage unchanged, and gnt[r] is never set without req_vld[r].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | NREQ | Request present, one bit per requester |
| req_wr | input | NREQ | 1 = store, 0 = fetch, one bit per requester |
| req_addr | input | NREQ*AW | Byte address, lane r at [r*AW +: AW] |
| req_wdata | input | NREQ*DW | Store data, lane r at [r*DW +: DW] |
| gnt | output | NREQ | Grant in the current cycle, one bit per requester |
| rd_vld | output | NREQ | Read data valid, one bit per requester |
| rd_data | output | NREQ*DW | Read data, lane r at [r*DW +: DW] |

## Verification
The assertions check four things on every cycle. An element never grants in the cycle right after one of its own grants. A store never wins an element while a fetch targets it. No requester is granted without a request. Every read strobe traces back to a read grant exactly five cycles earlier. The bench scenarios cover what the properties cannot show. These are the full fixed requester order across all 256 valid and kind combinations, and the exact 4-cycle and 7-cycle lockouts on every element. They also cover the data that returns for every address after a full write sweep, including the low address bits being ignored and a losing store leaving the storage untouched.

// File: rtl/stor_arb.sv
module stor_arb #(
  parameter int NREQ   = 4,
  parameter int NBANK  = 8,
  parameter int AW     = 24,
  parameter int DW     = 64,
  parameter int WPB    = 16,
  parameter int RD_CYC = 5,
  parameter int WR_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREQ-1:0]   req_vld,
  input  logic [NREQ-1:0]   req_wr,
  input  logic [NREQ*AW-1:0] req_addr,
  input  logic [NREQ*DW-1:0] req_wdata,
  output logic [NREQ-1:0]   gnt,
  output logic [NREQ-1:0]   rd_vld,
  output logic [NREQ*DW-1:0] rd_data
);
  localparam int BB  = $clog2(NBANK);
  localparam int WB  = $clog2(WPB);
  localparam int CW  = $clog2(WR_CYC + RD_CYC + 1);
  localparam int RET = 5;

  logic [BB-1:0] bsel [NREQ];
  logic [WB-1:0] wsel [NREQ];
  logic [DW-1:0] wdat [NREQ];

  for (genvar r = 0; r < NREQ; r++) begin : g_lane
    assign bsel[r] = req_addr[r*AW+3 +: BB];
    assign wsel[r] = req_addr[r*AW+3+BB +: WB];
    assign wdat[r] = req_wdata[r*DW +: DW];
  end

  logic [NREQ-1:0] bgnt [NBANK];
  logic [NBANK-1:0] bwr;
  logic [DW-1:0]   brd  [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [CW-1:0]   cnt;
    logic [NREQ-1:0] hit, fet, sto;
    logic [WB-1:0]   gw;
    logic [DW-1:0]   gd;
    logic [DW-1:0]   arr [WPB];

    for (genvar r = 0; r < NREQ; r++) begin : g_hit
      assign hit[r] = req_vld[r] && (bsel[r] == BB'(b));
    end
    assign fet = hit & ~req_wr;
    assign sto = hit &  req_wr;

    assign bgnt[b] = (cnt != '0) ? '0 :
                     (|fet)      ? (fet & (~fet + NREQ'(1))) :
                                   (sto & (~sto + NREQ'(1)));
    assign bwr[b]  = |(bgnt[b] & req_wr);

    always_comb begin
      gw = '0;
      gd = '0;
      for (int r = 0; r < NREQ; r++)
        if (bgnt[b][r]) begin
          gw = wsel[r];
          gd = wdat[r];
        end
    end

    assign brd[b] = arr[gw];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          cnt <= '0;
      else if (|bgnt[b])   cnt <= bwr[b] ? CW'(WR_CYC-1) : CW'(RD_CYC-1);
      else if (cnt != '0)  cnt <= cnt - CW'(1);

    always_ff @(posedge clk)
      if (bwr[b]) arr[gw] <= gd;

    AST_BANK_REST: assert property (@(posedge clk) disable iff (!rst_n)
      (|bgnt[b]) |=> !(|bgnt[b])); // R5
    AST_FETCH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      bwr[b] |-> (fet == '0)); // R3
  end

  always_comb begin
    gnt = '0;
    for (int b = 0; b < NBANK; b++) gnt = gnt | bgnt[b];
  end

  logic [NREQ-1:0] pv [RET];
  logic [DW-1:0]   pd [RET][NREQ];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int s = 0; s < RET; s++) pv[s] <= '0;
    end else begin
      pv[0] <= gnt & ~req_wr;
      for (int s = 1; s < RET; s++) pv[s] <= pv[s-1];
    end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREQ; r++) pd[0][r] <= brd[bsel[r]];
    for (int s = 1; s < RET; s++) pd[s] <= pd[s-1];
  end

  assign rd_vld = pv[RET-1];

  for (genvar r = 0; r < NREQ; r++) begin : g_out
    assign rd_data[r*DW +: DW] = pd[RET-1][r];

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld[r] |-> $past(gnt[r] && !req_wr[r], RET)); // R7
    AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[r] |-> req_vld[r]); // R8
  end
endmodule

// File: tb/tb_stor_arb.sv
module tb_stor_arb;
  localparam int AW = 24, DW = 64;
  logic clk = 0, rst_n = 0;
  logic [3:0] req_vld = 0, req_wr = 0;
  logic [4*AW-1:0] req_addr = '0;
  logic [4*DW-1:0] req_wdata = '0;
  logic [3:0] gnt, rd_vld;
  logic [4*DW-1:0] rd_data;

  stor_arb dut (.clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .gnt(gnt), .rd_vld(rd_vld), .rd_data(rd_data));

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [63:0] exp_mem [128];

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic set_req(int r, bit w, int bank, int word, logic [63:0] d);
    req_vld[r] = 1'b1;
    req_wr[r] = w;
    req_addr[r*AW +: AW] = AW'((word << 6) | (bank << 3));
    req_wdata[r*DW +: DW] = d;
  endtask

  task automatic clr();
    req_vld = '0;
    req_wr = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(int r, int bank, int word, logic [2:0] low, string tag);
    @(negedge clk);
    clr();
    set_req(r, 1'b0, bank, word, '0);
    req_addr[r*AW +: 3] = low;
    #1 chk({tag, " R1 grant"}, 64'(gnt), 64'(4'b1 << r));
    @(negedge clk);
    clr();
    idle(3);
    #1 chk({tag, " R7 early"}, 64'(rd_vld), 64'd0);
    @(negedge clk);
    #1 chk({tag, " R7 valid"}, 64'(rd_vld), 64'(4'b1 << r));
    chk({tag, " R7 data"}, rd_data[r*DW +: DW], exp_mem[bank*16+word]);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R2 reset rd_vld", 64'(rd_vld), 64'd0);
    chk("R2 reset gnt", 64'(gnt), 64'd0);
    rst_n = 1;
    @(negedge clk);
    set_req(3, 1'b1, 0, 0, 64'h1);
    #1 chk("R2 idle after reset", 64'(gnt), 64'h8);
    exp_mem[0] = 64'h1;
    @(negedge clk);
    clr();
    idle(8);

    // write sweep, one per cycle; each element is revisited exactly 8 cycles later (R5)
    for (int i = 0; i < 128; i++) begin
      int b, w, r;
      logic [63:0] d;
      b = i % 8; w = i / 8; r = i % 4;
      d = {16'hA5A5, 16'(i), 16'(b), 16'(w)};
      clr();
      set_req(r, 1'b1, b, w, d);
      #1 chk(i >= 8 ? "R5 write reuse at c+8" : "R6 write sweep", 64'(gnt), 64'(4'b1 << r));
      exp_mem[b*16+w] = d;
      @(negedge clk);
    end
    clr();
    idle(8);

    // read sweep over every address
    for (int i = 0; i < 128; i++)
      do_read(i % 4, i % 8, i / 8, 3'(i % 3 == 0 ? 7 : 0), "sweep");
    idle(8);

    // priority sweep: all valid/kind combinations on one element
    for (int m = 0; m < 256; m++) begin
      logic [3:0] vm, wm, f, s, e;
      int b;
      vm = 4'(m); wm = 4'(m >> 4); b = m % 8;
      clr();
      for (int r = 0; r < 4; r++)
        if (vm[r]) set_req(r, wm[r], b, r, {16'(m), 16'(r), 32'h5A5A_0000});
      f = vm & ~wm; s = vm & wm;
      e = 0;
      if (f != 0) begin
        for (int r = 3; r >= 0; r--) if (f[r]) e = 4'b1 << r;
      end else begin
        for (int r = 3; r >= 0; r--) if (s[r]) e = 4'b1 << r;
      end
      #1 chk((f != 0 && s != 0) ? "R3 fetch over store" : "R4 fixed order", 64'(gnt), 64'(e));
      for (int r = 0; r < 4; r++)
        if (e[r] && wm[r]) exp_mem[b*16+r] = {16'(m), 16'(r), 32'h5A5A_0000};
      @(negedge clk);
      clr();
      idle(8);
    end

    // losing store has no effect (R8)
    @(negedge clk);
    set_req(0, 1'b0, 5, 9, '0);
    set_req(1, 1'b1, 5, 9, 64'hDEAD_BEEF_0BAD_F00D);
    #1 chk("R3 losing store not granted", 64'(gnt), 64'h1);
    @(negedge clk);
    clr();
    idle(8);
    do_read(2, 5, 9, 3'd0, "R8 store dropped");
    idle(8);

    // element lockout after read and write
    for (int b = 0; b < 8; b++)
      for (int w = 0; w < 2; w++) begin
        int den;
        logic [63:0] d;
        d = {32'hB00C, 16'(b), 16'(w)};
        @(negedge clk);
        clr();
        set_req(0, w[0], b, 3, d);
        #1 chk("R5 first grant", 64'(gnt), 64'h1);
        if (w == 1) exp_mem[b*16+3] = d;
        @(negedge clk);
        clr();
        set_req(1, 1'b0, b, 4, '0);
        set_req(2, 1'b0, (b + 1) % 8, 5, '0);
        #1 chk("R6 other element during lockout", 64'(gnt), 64'h4);
        den = 0;
        while (!gnt[1] && den < 20) begin
          den++;
          @(negedge clk);
          req_vld[2] = 1'b0;
          #1;
        end
        chk(w == 1 ? "R5 write lockout cycles" : "R5 read lockout cycles",
            64'(den), 64'(w == 1 ? 7 : 4));
        @(negedge clk);
        clr();
        idle(8);
      end

    // four elements in parallel, all read back together
    @(negedge clk);
    clr();
    for (int r = 0; r < 4; r++) set_req(r, 1'b0, 2*r+1, 2, '0);
    #1 chk("R6 parallel grants", 64'(gnt), 64'hF);
    @(negedge clk);
    clr();
    idle(3);
    #1 chk("R7 parallel early", 64'(rd_vld), 64'd0);
    @(negedge clk);
    #1 chk("R7 parallel valid", 64'(rd_vld), 64'hF);
    for (int r = 0; r < 4; r++)
      chk("R7 parallel data", rd_data[r*DW +: DW], exp_mem[(2*r+1)*16+2]);
    idle(8);

    // mixed stores and fetches on separate elements
    @(negedge clk);
    set_req(0, 1'b1, 6, 7, 64'h6666);
    set_req(1, 1'b0, 7, 7, '0);
    set_req(2, 1'b1, 0, 7, 64'h0707);
    set_req(3, 1'b0, 1, 7, '0);
    #1 chk("R6 mixed grants", 64'(gnt), 64'hF);
    exp_mem[6*16+7] = 64'h6666;
    exp_mem[0*16+7] = 64'h0707;
    @(negedge clk);
    clr();
    idle(8);
    do_read(3, 6, 7, 3'd5, "R1 mixed readback");
    do_read(1, 0, 7, 3'd2, "R1 mixed readback");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule